// File: doc/BRIEF.md
# Disk Multi-Sector Read Sequencer

This block runs a whole sector read against a hard disk drive that has a built-in controller, from the host side. Its far side is a simple register-access port: one request at a time, held until the port acknowledges it. Behind that port sits the drive's eight-register command block. A client gives a cylinder, head, starting sector, drive select, sector count and retry option, then pulses `start`. The block writes the parameter registers and then writes the read command. It then polls the status register and moves each 256-word sector out on a valid/ready word stream.

Before every sector the drive reports busy while it fetches data, so the block polls again until the data-request flag shows. A count of zero means 256 sectors. The transfer ends with one `done` pulse and a result code. On success the block first reads back the sector count register and checks that it is zero. On a drive error it reads the error code and the failing address out of the drive. If the drive stays busy longer than a client-set number of cycles, it reports a timeout. The stream never drops a word: a data register read is only issued when the output slot is free.

Top module: `ide_read_seq`

## Requirements
- R1: After `start`, the block writes exactly six registers, and the command register (offset 7) is written last. The five parameter writes are count (offset 2), start sector (offset 3), cylinder low byte (offset 4), cylinder high byte (offset 5) and the select byte (offset 6). The select byte is 0xA0 | drive<<4 | head.
- R2: The command byte is 0x20 | `no_retry`. Bits 2 and 1 are always zero.
- R3: Before each sector, status (offset 7) is read repeatedly. Data (offset 0) is only read after a status read shows busy (bit 7) clear and data request (bit 3) set, and the request is held stable until it is acknowledged.
- R4: Exactly 256 data reads are made per sector. The words leave on the stream in the order they were read, and `out_last` marks the 256th word of each sector.
- R5: A count of 0 transfers 256 sectors (65536 words).
- R6: While the output word is held with `out_ready` low, no data read is issued. The held word stays stable, and no word is lost or repeated.
- R7: A status read with busy clear and the error bit (bit 0) set ends the transfer. The block then reads the error register (offset 1), sector, cylinder and select registers, and reports result 1 with `err_code`, `fail_sector`, `fail_cyl` and `fail_head` taken from them. No further data is read.
- R8: If polling lasts `poll_limit` cycles or more without the status allowing progress, the transfer ends with result 2. This happens no earlier than `poll_limit` cycles after the command write.
- R9: After the last sector, status is polled until busy clears. The count register (offset 2) is then read: zero gives result 0, and nonzero gives result 3. `done` pulses for one cycle with the result on `status`.
- R10: After reset, `bus_req`, `out_valid`, `done` and `active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| no_retry | input | 1 | Disable drive retries (command bit 0) |
| cyl | input | 16 | Starting cylinder |
| head | input | 4 | Head number |
| sector | input | 8 | Starting sector number |
| drive | input | 1 | Drive select |
| count | input | 8 | Sector count, 0 means 256 |
| poll_limit | input | TMO_W | Poll timeout in cycles |
| bus_req | output | 1 | Register access request, held until ack |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 3 | Register offset in the command block |
| bus_wdata | output | DATA_W | Write data (byte in low bits) |
| bus_ack | input | 1 | Access completed this cycle |
| bus_rdata | input | DATA_W | Read data, valid with ack |
| out_valid | output | 1 | Stream word valid |
| out_data | output | DATA_W | Stream word |
| out_last | output | 1 | Last word of a sector |
| out_ready | input | 1 | Downstream accepts the word |
| active | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 drive error, 2 timeout, 3 count mismatch |
| err_code | output | 8 | Error register contents on result 1 |
| fail_cyl | output | 16 | Failing cylinder on result 1 |
| fail_head | output | 4 | Failing head on result 1 |
| fail_sector | output | 8 | Failing sector on result 1 |

## Verification
A word counter that slips shows up at once in the stream. `out_last` falls on the wrong word, and the following word carries the next sector's number before the drive has raised data request again, so the model records an illegal read within one access. A wrong decision in the poll state shows within a few cycles: data is read during busy, the error path is skipped, or a stalled drive never times out. Each of these shows as a wrong result code or a wrong word total on the stream. A lost or repeated word under back-pressure breaks the strict sector/word sequence that the bench expects on the next accepted word.

// File: rtl/ide_rd_pkg.sv
`timescale 1ns/1ps
package ide_rd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_LOAD, SQ_POLL, SQ_DATA, SQ_ERRRD, SQ_CNT
  } seq_state_t;

  typedef enum logic [1:0] {
    RES_OK = 2'd0, RES_DEVERR = 2'd1, RES_TIMEOUT = 2'd2, RES_CNTERR = 2'd3
  } result_t;

  // register offsets decoded by the drive
  localparam logic [2:0] TF_DATA   = 3'd0;
  localparam logic [2:0] TF_ERROR  = 3'd1;
  localparam logic [2:0] TF_COUNT  = 3'd2;
  localparam logic [2:0] TF_SECTOR = 3'd3;
  localparam logic [2:0] TF_CYL_LO = 3'd4;
  localparam logic [2:0] TF_CYL_HI = 3'd5;
  localparam logic [2:0] TF_SELECT = 3'd6;
  localparam logic [2:0] TF_CMD    = 3'd7;

  // status bit positions
  localparam int SB_BUSY = 7;
  localparam int SB_DRQ  = 3;
  localparam int SB_ERR  = 0;

  localparam logic [7:0] CMD_READ_BASE = 8'h20;
  localparam logic [7:0] SEL_BASE      = 8'hA0;
  localparam logic [2:0] LOAD_LAST     = 3'd5;
  localparam logic [2:0] ERRRD_LAST    = 3'd4;

  // parameter registers first, command last
  function automatic logic [2:0] load_addr(input logic [2:0] idx);
    case (idx)
      3'd0:    load_addr = TF_COUNT;
      3'd1:    load_addr = TF_SECTOR;
      3'd2:    load_addr = TF_CYL_LO;
      3'd3:    load_addr = TF_CYL_HI;
      3'd4:    load_addr = TF_SELECT;
      default: load_addr = TF_CMD;
    endcase
  endfunction

  function automatic logic [2:0] errrd_addr(input logic [2:0] idx);
    case (idx)
      3'd0:    errrd_addr = TF_ERROR;
      3'd1:    errrd_addr = TF_SECTOR;
      3'd2:    errrd_addr = TF_CYL_LO;
      3'd3:    errrd_addr = TF_CYL_HI;
      default: errrd_addr = TF_SELECT;
    endcase
  endfunction

endpackage

// File: rtl/ide_rd_poll_timer.sv
`timescale 1ns/1ps
module ide_rd_poll_timer #(
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

  // R8: the count only grows while polling, one step per cycle
  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) && !$past(rst) && $past(cnt) != CNT_MAX |-> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/ide_rd_word_ctr.sv
`timescale 1ns/1ps
module ide_rd_word_ctr #(
  parameter int WORDS = 256,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] count_in,
  input  logic             word_step,
  output logic             last_word,
  output logic             no_more
);
  localparam int MAX_SECT = 1 << CNT_W;
  localparam int SEC_W    = CNT_W + 1;
  localparam int WRD_W    = $clog2(WORDS);

  logic [WRD_W-1:0] wcnt;
  logic [SEC_W-1:0] sec_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt     <= '0;
      sec_left <= '0;
    end else if (load) begin
      wcnt     <= '0;
      sec_left <= (count_in == '0) ? SEC_W'(MAX_SECT) : SEC_W'(count_in);
    end else if (word_step) begin
      if (last_word) begin
        wcnt     <= '0;
        sec_left <= sec_left - 1'b1;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  assign last_word = (wcnt == WRD_W'(WORDS - 1));
  assign no_more   = (sec_left == '0);

  // R5: a word is never read once all sectors are done
  p_sect_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    word_step |-> !no_more);
endmodule

// File: rtl/ide_rd_out_slot.sv
`timescale 1ns/1ps
module ide_rd_out_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         last_in,
  input  logic         rdy,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         last_out,
  output logic         free
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      dout     <= '0;
      last_out <= 1'b0;
    end else if (load) begin
      valid    <= 1'b1;
      dout     <= din;
      last_out <= last_in;
    end else if (rdy) begin
      valid <= 1'b0;
    end
  end

  assign free = !valid || rdy;

  // R6: a held word stays put until taken
  p_hold_word_r6: assert property (@(posedge clk) disable iff (rst)
    valid && !rdy |=> valid && $stable(dout) && $stable(last_out));
endmodule

// File: rtl/ide_read_seq.sv
`timescale 1ns/1ps
module ide_read_seq
  import ide_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORDS  = 256,
  parameter int CNT_W  = 8,
  parameter int TMO_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              no_retry,
  input  logic [15:0]       cyl,
  input  logic [3:0]        head,
  input  logic [7:0]        sector,
  input  logic              drive,
  input  logic [CNT_W-1:0]  count,
  input  logic [TMO_W-1:0]  poll_limit,
  output logic              bus_req,
  output logic              bus_we,
  output logic [2:0]        bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              active,
  output logic              done,
  output logic [1:0]        status,
  output logic [7:0]        err_code,
  output logic [15:0]       fail_cyl,
  output logic [3:0]        fail_head,
  output logic [7:0]        fail_sector
);
  localparam int PAD_W = DATA_W - 8;

  seq_state_t       state;
  logic [2:0]       idx;
  logic [7:0]       p_count, p_sector, p_sel, p_cmd;
  logic [15:0]      p_cyl;
  logic [TMO_W-1:0] p_limit;
  logic [7:0]       ld_val;
  logic [7:0]       st_byte;
  logic             acked, data_ack, take_start;
  logic             last_word, no_more, tmo_expired, slot_free;

  assign acked      = bus_req && bus_ack;
  assign data_ack   = acked && (state == SQ_DATA);
  assign take_start = start && (state == SQ_IDLE);
  assign st_byte    = bus_rdata[7:0];

  always_comb begin
    case (idx)
      3'd0:    ld_val = p_count;
      3'd1:    ld_val = p_sector;
      3'd2:    ld_val = p_cyl[7:0];
      3'd3:    ld_val = p_cyl[15:8];
      3'd4:    ld_val = p_sel;
      default: ld_val = p_cmd;
    endcase
  end

  ide_rd_word_ctr #(.WORDS(WORDS), .CNT_W(CNT_W)) u_words (
    .clk(clk), .rst(rst), .load(take_start), .count_in(count),
    .word_step(data_ack), .last_word(last_word), .no_more(no_more)
  );

  ide_rd_poll_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst(rst), .run(state == SQ_POLL), .limit(p_limit),
    .expired(tmo_expired)
  );

  ide_rd_out_slot #(.W(DATA_W)) u_slot (
    .clk(clk), .rst(rst), .load(data_ack), .din(bus_rdata), .last_in(last_word),
    .rdy(out_ready), .valid(out_valid), .dout(out_data), .last_out(out_last),
    .free(slot_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      idx         <= '0;
      bus_req     <= 1'b0;
      bus_we      <= 1'b0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      active      <= 1'b0;
      done        <= 1'b0;
      status      <= RES_OK;
      err_code    <= '0;
      fail_cyl    <= '0;
      fail_head   <= '0;
      fail_sector <= '0;
      p_count     <= '0;
      p_sector    <= '0;
      p_sel       <= '0;
      p_cmd       <= '0;
      p_cyl       <= '0;
      p_limit     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            p_count     <= 8'(count);
            p_sector    <= sector;
            p_cyl       <= cyl;
            p_sel       <= SEL_BASE | {3'b000, drive, head};
            p_cmd       <= CMD_READ_BASE | {7'b0, no_retry};   // R2
            p_limit     <= poll_limit;
            idx         <= '0;
            active      <= 1'b1;
            err_code    <= '0;
            fail_cyl    <= '0;
            fail_head   <= '0;
            fail_sector <= '0;
            state       <= SQ_LOAD;
          end
        end
        SQ_LOAD: begin                                        // R1
          if (!bus_req) begin
            bus_req   <= 1'b1;
            bus_we    <= 1'b1;
            bus_addr  <= load_addr(idx);
            bus_wdata <= {{PAD_W{1'b0}}, ld_val};
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            bus_we  <= 1'b0;
            if (idx == LOAD_LAST) state <= SQ_POLL;
            else idx <= idx + 1'b1;
          end
        end
        SQ_POLL: begin                                        // R3, R8, R9
          if (!bus_req) begin
            bus_req  <= 1'b1;
            bus_addr <= TF_CMD;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            if (!st_byte[SB_BUSY] && st_byte[SB_ERR]) begin
              idx   <= '0;
              state <= SQ_ERRRD;
            end else if (!st_byte[SB_BUSY] && no_more) begin
              state <= SQ_CNT;
            end else if (!st_byte[SB_BUSY] && st_byte[SB_DRQ]) begin
              state <= SQ_DATA;
            end else if (tmo_expired) begin
              status <= RES_TIMEOUT;
              done   <= 1'b1;
              active <= 1'b0;
              state  <= SQ_IDLE;
            end
          end
        end
        SQ_DATA: begin                                        // R4, R6
          if (!bus_req) begin
            if (slot_free) begin
              bus_req  <= 1'b1;
              bus_addr <= TF_DATA;
            end
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            if (last_word) state <= SQ_POLL;
          end
        end
        SQ_ERRRD: begin                                       // R7
          if (!bus_req) begin
            bus_req  <= 1'b1;
            bus_addr <= errrd_addr(idx);
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            case (idx)
              3'd0:    err_code       <= st_byte;
              3'd1:    fail_sector    <= st_byte;
              3'd2:    fail_cyl[7:0]  <= st_byte;
              3'd3:    fail_cyl[15:8] <= st_byte;
              default: fail_head      <= st_byte[3:0];
            endcase
            if (idx == ERRRD_LAST) begin
              status <= RES_DEVERR;
              done   <= 1'b1;
              active <= 1'b0;
              state  <= SQ_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        SQ_CNT: begin                                         // R9
          if (!bus_req) begin
            bus_req  <= 1'b1;
            bus_addr <= TF_COUNT;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            status  <= (st_byte == 8'h00) ? RES_OK : RES_CNTERR;
            done    <= 1'b1;
            active  <= 1'b0;
            state   <= SQ_IDLE;
          end
        end
        default: begin
          bus_req <= 1'b0;
          state   <= SQ_IDLE;
        end
      endcase
    end
  end

  // R3: an access is held unchanged until acknowledged
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  // R1: the command write comes only after the five parameter writes
  p_cmd_last_r1: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && bus_addr == TF_CMD |-> idx == LOAD_LAST);

  // R6: a data read is only outstanding while the output slot is empty
  p_room_for_word_r6: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_we && bus_addr == TF_DATA |-> !out_valid);

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/sim_ide_read_seq.sv
`timescale 1ns/1ps
module sim_ide_read_seq;
  localparam int TMO_W    = 20;
  localparam int BUSY_DLY = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        no_retry = 1'b0;
  logic [15:0] cyl = '0;
  logic [3:0]  head = '0;
  logic [7:0]  sector = '0;
  logic        drive = 1'b0;
  logic [7:0]  count = '0;
  logic [TMO_W-1:0] poll_limit = '0;
  logic        bus_req, bus_we, bus_ack;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        out_valid, out_last;
  logic [15:0] out_data;
  logic        out_ready = 1'b1;
  logic        active, done;
  logic [1:0]  status;
  logic [7:0]  err_code, fail_sector;
  logic [15:0] fail_cyl;
  logic [3:0]  fail_head;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  ide_read_seq u0 (
    .clk(clk), .rst(rst), .start(start), .no_retry(no_retry), .cyl(cyl),
    .head(head), .sector(sector), .drive(drive), .count(count),
    .poll_limit(poll_limit), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready), .active(active), .done(done),
    .status(status), .err_code(err_code), .fail_cyl(fail_cyl),
    .fail_head(fail_head), .fail_sector(fail_sector)
  );

  // ---------------- drive model ----------------
  int  cfg_err_at = -1;
  bit  cfg_stuck  = 1'b0;
  bit  cfg_bad_sc = 1'b0;
  int  rdy_mode   = 0;

  logic [7:0] m_sc, m_sn, m_cl, m_ch, m_sel, m_er;
  logic       m_drq, m_err;
  int         m_busy, m_rem, m_secs, m_widx, m_viol, log_n;
  logic [2:0] log_a [0:63];
  logic [7:0] log_d [0:63];
  logic [7:0] m_status;

  assign bus_ack  = bus_req;
  assign m_status = {(m_busy != 0) || cfg_stuck, 1'b1, 1'b0, 1'b1, m_drq, 2'b00, m_err};

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {m_sn, m_widx[7:0]};
      3'd1:    bus_rdata = {8'h00, m_er};
      3'd2:    bus_rdata = {8'h00, m_sc};
      3'd3:    bus_rdata = {8'h00, m_sn};
      3'd4:    bus_rdata = {8'h00, m_cl};
      3'd5:    bus_rdata = {8'h00, m_ch};
      3'd6:    bus_rdata = {8'h00, m_sel};
      default: bus_rdata = {8'h00, m_status};
    endcase
  end

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_drq <= 1'b0; m_err <= 1'b0; m_viol <= 0; log_n <= 0;
      m_sc <= '0; m_sn <= '0; m_cl <= '0; m_ch <= '0; m_sel <= '0; m_er <= '0;
      m_rem <= 0; m_secs <= 0; m_widx <= 0;
    end else begin
      if (m_busy != 0) begin
        m_busy <= m_busy - 1;
        if (m_busy == 1) begin
          if (m_secs == cfg_err_at) begin m_err <= 1'b1; m_er <= 8'h10; end
          else m_drq <= 1'b1;
        end
      end
      if (bus_req && bus_ack) begin
        if (bus_we) begin
          if (log_n < 64) begin
            log_a[log_n] <= bus_addr;
            log_d[log_n] <= bus_wdata[7:0];
          end
          log_n <= log_n + 1;
          case (bus_addr)
            3'd2: m_sc  <= bus_wdata[7:0];
            3'd3: m_sn  <= bus_wdata[7:0];
            3'd4: m_cl  <= bus_wdata[7:0];
            3'd5: m_ch  <= bus_wdata[7:0];
            3'd6: m_sel <= bus_wdata[7:0];
            3'd7: begin
              m_busy <= BUSY_DLY; m_drq <= 1'b0; m_err <= 1'b0;
              m_secs <= 0; m_widx <= 0;
              m_rem  <= (m_sc == 8'd0) ? 256 : int'(m_sc);
            end
            default: ;
          endcase
        end else if (bus_addr == 3'd0) begin
          if (!m_drq) m_viol <= m_viol + 1;
          else if (m_widx == 255) begin
            m_widx <= 0; m_drq <= 1'b0; m_secs <= m_secs + 1; m_rem <= m_rem - 1;
            if (m_rem == 1) m_sc <= cfg_bad_sc ? 8'd1 : 8'd0;
            else begin m_sc <= m_sc - 1'b1; m_sn <= m_sn + 1'b1; m_busy <= BUSY_DLY; end
          end else m_widx <= m_widx + 1;
        end
      end
    end
  end

  // ---------------- stream monitor ----------------
  int         mon_words = 0, mon_mism = 0, mon_lasts = 0;
  logic [7:0] exp_sn = '0, exp_w = '0;
  logic [7:0] lfsr = 8'h5A;

  initial begin
    forever begin
      @(negedge clk);
      lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
      #1;
      if (start) begin exp_sn = sector; exp_w = 8'd0; end
      if (!rst && out_valid && out_ready) begin
        mon_words++;
        if (out_data != {exp_sn, exp_w} || out_last != (exp_w == 8'd255)) mon_mism++;
        if (out_last) mon_lasts++;
        if (exp_w == 8'd255) exp_sn = exp_sn + 1'b1;
        exp_w = exp_w + 1'b1;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, expv, expv);
    end
  endtask

  int r_words, r_mism, r_lasts, r_viol, r_log0, r_cycles;

  task automatic run_xfer(input logic [15:0] c, input logic [3:0] h, input logic [7:0] s,
                          input logic d, input logic [7:0] n, input logic nr,
                          input int lim);
    int w0, m0, l0, v0;
    @(negedge clk);
    w0 = mon_words; m0 = mon_mism; l0 = mon_lasts; v0 = m_viol; r_log0 = log_n;
    cyl = c; head = h; sector = s; drive = d; count = n; no_retry = nr;
    poll_limit = TMO_W'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_cycles = 1;
    while (!done && r_cycles < 170000) begin
      @(negedge clk);
      r_cycles++;
    end
    repeat (30) @(negedge clk);
    r_words = mon_words - w0; r_mism = mon_mism - m0;
    r_lasts = mon_lasts - l0; r_viol = m_viol - v0;
  endtask

  task automatic check_params(input logic [7:0] n, input logic [7:0] s, input logic [15:0] c,
                              input logic [7:0] sel, input logic [7:0] cmd);
    check(log_n - r_log0 == 6, "R1 write count", log_n - r_log0, 6);
    check(log_a[r_log0+5] == 3'd7, "R1 command written last", int'(log_a[r_log0+5]), 7);
    for (int i = 0; i < 5; i++) begin
      case (log_a[r_log0+i])
        3'd2: check(log_d[r_log0+i] == n, "R1 count reg", int'(log_d[r_log0+i]), int'(n));
        3'd3: check(log_d[r_log0+i] == s, "R1 sector reg", int'(log_d[r_log0+i]), int'(s));
        3'd4: check(log_d[r_log0+i] == c[7:0], "R1 cyl lo reg", int'(log_d[r_log0+i]), int'(c[7:0]));
        3'd5: check(log_d[r_log0+i] == c[15:8], "R1 cyl hi reg", int'(log_d[r_log0+i]), int'(c[15:8]));
        3'd6: check(log_d[r_log0+i] == sel, "R1 select byte", int'(log_d[r_log0+i]), int'(sel));
        default: check(1'b0, "R1 unexpected param address", int'(log_a[r_log0+i]), 2);
      endcase
    end
    check(log_d[r_log0+5] == cmd, "R2 command byte", int'(log_d[r_log0+5]), int'(cmd));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    @(negedge clk);
    check(!bus_req && !out_valid && !done && !active, "R10 reset state",
          int'({bus_req, out_valid, done, active}), 0);
  endtask

  task automatic t_basic;
    run_xfer(16'h1234, 4'd5, 8'd7, 1'b0, 8'd3, 1'b0, 5000);
    check_params(8'd3, 8'd7, 16'h1234, 8'hA5, 8'h20);
    check(r_words == 768, "R4 words for 3 sectors", r_words, 768);
    check(r_mism == 0, "R4 word order and last flag", r_mism, 0);
    check(r_lasts == 3, "R4 last markers", r_lasts, 3);
    check(r_viol == 0, "R3 no data read without request", r_viol, 0);
    check(status == 2'd0, "R9 success result", int'(status), 0);
  endtask

  task automatic t_retry_off;
    run_xfer(16'h00FF, 4'hF, 8'd1, 1'b1, 8'd1, 1'b1, 5000);
    check_params(8'd1, 8'd1, 16'h00FF, 8'hBF, 8'h21);
    check(r_words == 256 && r_mism == 0, "R4 single sector", r_words, 256);
    check(status == 2'd0, "R9 success result", int'(status), 0);
  endtask

  task automatic t_stall;
    rdy_mode = 1;
    run_xfer(16'h0042, 4'd2, 8'd30, 1'b0, 8'd2, 1'b0, 5000);
    rdy_mode = 0;
    check(r_words == 512, "R6 word total under back-pressure", r_words, 512);
    check(r_mism == 0, "R6 no lost or repeated word", r_mism, 0);
    check(r_viol == 0, "R3 no early data read", r_viol, 0);
  endtask

  task automatic t_error;
    cfg_err_at = 2;
    run_xfer(16'h0321, 4'd3, 8'd10, 1'b0, 8'd4, 1'b0, 5000);
    cfg_err_at = -1;
    check(status == 2'd1, "R7 error result", int'(status), 1);
    check(err_code == 8'h10, "R7 error code", int'(err_code), 16);
    check(fail_sector == 8'd12, "R7 failing sector", int'(fail_sector), 12);
    check(fail_cyl == 16'h0321, "R7 failing cylinder", int'(fail_cyl), 16'h0321);
    check(fail_head == 4'd3, "R7 failing head", int'(fail_head), 3);
    check(r_words == 512, "R7 no data after error", r_words, 512);
  endtask

  task automatic t_timeout;
    cfg_stuck = 1'b1;
    run_xfer(16'h0001, 4'd0, 8'd1, 1'b0, 8'd1, 1'b0, 200);
    cfg_stuck = 1'b0;
    check(status == 2'd2, "R8 timeout result", int'(status), 2);
    check(r_cycles >= 200, "R8 not before limit", r_cycles, 200);
    check(r_words == 0 && r_viol == 0, "R8 no data while busy", r_words, 0);
  endtask

  task automatic t_count_left;
    cfg_bad_sc = 1'b1;
    run_xfer(16'h0010, 4'd1, 8'd5, 1'b0, 8'd1, 1'b0, 5000);
    cfg_bad_sc = 1'b0;
    check(status == 2'd3, "R9 count mismatch result", int'(status), 3);
    check(r_words == 256, "R9 data still delivered", r_words, 256);
  endtask

  task automatic t_full;
    run_xfer(16'h0200, 4'd0, 8'd1, 1'b0, 8'd0, 1'b0, 5000);
    check(r_words == 65536, "R5 count zero gives 256 sectors", r_words, 65536);
    check(r_lasts == 256 && r_mism == 0, "R5 sector boundaries", r_lasts, 256);
    check(status == 2'd0, "R5 success result", int'(status), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_retry_off();
    t_stall();
    t_error();
    t_timeout();
    t_count_left();
    t_full();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule